// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers up to thirty-two interrupt request lines and turns them into two processor-facing requests: an ordinary one and an urgent one. Each line first passes through a two-flop synchroniser. The line's own polarity setting then corrects its sense. Its own sense setting decides whether it is sampled as a level or as a rising edge of the corrected signal. Any event sets a sticky status bit, and software clears that bit by writing 1 to it.

An enable register masks the status register. Each masked bit then goes to one of the two outputs, as its routing bit decides. The controller also reports the number of the most urgent pending source, where a lower number means more urgent. It gives this number on dedicated output pins and in a read-only register.

All registers use reversed numbering: source n lives at register bit 31-n. A fixed range of sources, 17 to 19 by default, is reserved. Software sees the controller through a small word-addressed register port. Writes take effect at the clock edge, and read data is registered, so it appears one cycle after the read request.

Top module: `irq_hub`

## Requirements
- R1: Source n (input `irq_src[n]`) is represented at register bit 31-n in every per-source register, so source 0 is bit 31.
- R2: Writing the status register (offset 0x00) with a 1 in a bit clears that bit; a 0 leaves it unchanged; status bits never fall otherwise.
- R3: A level-sensitive source (sense bit 0, register 0x10) sets its status bit on every cycle its corrected input is asserted, so a clear while the level persists leaves the bit set.
- R4: An edge-sensitive source (sense bit 1) sets its status bit only on a 0-to-1 transition of its corrected input; a clear while the input stays high leaves the bit 0.
- R5: Polarity bit 1 (register 0x0C) makes a source active high; polarity bit 0 makes it active low.
- R6: `irq_norm` is the OR of masked bits whose routing bit (register 0x08) is 1, and `irq_crit` is the OR of masked bits whose routing bit is 0.
- R7: The masked register (offset 0x14, read-only) reads as status AND enable (enable at offset 0x04).
- R8: The pending register (offset 0x18) reads {valid in bit 31, zeros, source number in bits 4:0}. The number is the lowest-numbered source with a masked bit set, and valid is 0 with number 0 when no masked bit is set. `top_valid` and `top_id` carry the same values.
- R9: Sources 17, 18 and 19 (bits 14, 13, 12) always read 0 in status and enable, ignoring writes and input activity.
- R10: After reset, every register is 0, both outputs are low, and with all inputs low every non-reserved status bit becomes set, because the sources are active low and level sensitive.
- R11: Read data appears one cycle after a read request and holds until the next read; offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw interrupt lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_norm | output | 1 | Ordinary interrupt request |
| irq_crit | output | 1 | Urgent interrupt request |
| top_valid | output | 1 | Some masked source is pending |
| top_id | output | 5 | Number of the most urgent pending source |

## Verification
Directed patterns place a single source at a time to check the reversed bit mapping. The same patterns hold a level through a clear, which separates level behaviour from edge behaviour. They also drive a reserved source, which shows that it cannot reach status. Random patterns mix input values, polarity, enable and routing words across all sources. These expose any wrong polarity sense, any leak through the mask, or a wrong output choice. Each random pattern is also checked for the pending number, which separates a lowest-number-first encoder from one that scans the other way.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC   = 32;
  localparam int ID_W   = $clog2(NSRC);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_EN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CRIT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_POL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_PEND = 5'h18;

  // register-bit mask of a reserved source range (source n at bit NSRC-1-n)
  function automatic logic [NSRC-1:0] rsvd_mask(input int lo, input int hi);
    logic [NSRC-1:0] m;
    m = '0;
    for (int n = 0; n < NSRC; n++)
      if (n >= lo && n <= hi) m[NSRC-1-n] = 1'b1;
    return m;
  endfunction

  // lowest-numbered source whose register bit is set (0 when none)
  function automatic logic [ID_W-1:0] first_src(input logic [NSRC-1:0] v);
    logic [ID_W-1:0] id;
    id = '0;
    for (int n = NSRC-1; n >= 0; n--)
      if (v[NSRC-1-n]) id = ID_W'(n);
    return id;
  endfunction
endpackage

// File: rtl/irq_hub_cond.sv
module irq_hub_cond
  import irq_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] trig,
  output logic [NSRC-1:0] set_ev
);
  logic [SYNC_STAGES-1:0][NSRC-1:0] sync_q;
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= active;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // polarity 1: high is active; polarity 0: low is active
    assign active[i] = ~(sync_q[SYNC_STAGES-1][i] ^ pol[i]);
    assign set_ev[i] = trig[i] ? (active[i] & ~prev_q[i]) : active[i];
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
  import irq_hub_pkg::*;
(
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] crit,
  output logic [NSRC-1:0] masked,
  output logic            irq_norm,
  output logic            irq_crit,
  output logic            top_valid,
  output logic [ID_W-1:0] top_id
);
  assign masked    = stat & en;
  assign irq_norm  = |(masked & crit);
  assign irq_crit  = |(masked & ~crit);
  assign top_valid = |masked;
  assign top_id    = first_src(masked);
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter logic [NSRC-1:0] RSVD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   set_ev,
  input  logic [NSRC-1:0]   masked,
  input  logic              top_valid,
  input  logic [ID_W-1:0]   top_id,
  output logic [DATA_W-1:0] rdata,
  output logic [NSRC-1:0]   stat,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   crit,
  output logic [NSRC-1:0]   pol,
  output logic [NSRC-1:0]   trig
);
  logic [NSRC-1:0]   clr_bits;
  logic [DATA_W-1:0] rd_mux;

  assign clr_bits = (wr_en && addr == OFF_STAT) ? wdata : '0;

  always_comb begin
    unique case (addr)
      OFF_STAT: rd_mux = stat;
      OFF_EN:   rd_mux = en;
      OFF_CRIT: rd_mux = crit;
      OFF_POL:  rd_mux = pol;
      OFF_TRIG: rd_mux = trig;
      OFF_MSK:  rd_mux = masked;
      OFF_PEND: rd_mux = {top_valid, {(DATA_W-1-ID_W){1'b0}}, top_id};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      en    <= '0;
      crit  <= '0;
      pol   <= '0;
      trig  <= '0;
      rdata <= '0;
    end else begin
      // a new event in the clearing cycle is kept
      stat <= ((stat & ~clr_bits) | set_ev) & ~RSVD;
      if (wr_en) begin
        case (addr)
          OFF_EN:   en   <= wdata & ~RSVD;
          OFF_CRIT: crit <= wdata;
          OFF_POL:  pol  <= wdata;
          OFF_TRIG: trig <= wdata;
          default:  ;
        endcase
      end
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RSVD_LO     = 17,
  parameter int RSVD_HI     = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_norm,
  output logic              irq_crit,
  output logic              top_valid,
  output logic [ID_W-1:0]   top_id
);
  localparam logic [NSRC-1:0] RSVD = rsvd_mask(RSVD_LO, RSVD_HI);

  logic [NSRC-1:0] src_rev;
  logic [NSRC-1:0] set_ev;
  logic [NSRC-1:0] stat_q, en_q, crit_q, pol_q, trig_q, masked;

  // reversed numbering: source n at bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_rev
    assign src_rev[NSRC-1-n] = irq_src[n];
  end

  irq_hub_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(src_rev), .pol(pol_q), .trig(trig_q),
    .set_ev(set_ev)
  );

  irq_hub_regs #(.RSVD(RSVD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .set_ev(set_ev), .masked(masked), .top_valid(top_valid),
    .top_id(top_id), .rdata(rdata), .stat(stat_q), .en(en_q), .crit(crit_q),
    .pol(pol_q), .trig(trig_q)
  );

  irq_hub_prio u_prio (
    .stat(stat_q), .en(en_q), .crit(crit_q), .masked(masked),
    .irq_norm(irq_norm), .irq_crit(irq_crit), .top_valid(top_valid),
    .top_id(top_id)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter logic [NSRC-1:0] RSVD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NSRC-1:0]   set_ev,
  input logic [NSRC-1:0]   stat,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   crit,
  input logic              irq_norm,
  input logic              irq_crit,
  input logic              top_valid,
  input logic [ID_W-1:0]   top_id
);
  logic [NSRC-1:0] m;
  logic            stat_wr;
  assign m       = stat & en;
  assign stat_wr = wr_en && (addr == OFF_STAT);

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat | en) & RSVD) == '0);

  assert_norm_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm == |(m & crit));

  assert_crit_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit == |(m & ~crit));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (stat & $past(wdata) & ~$past(set_ev)) == '0);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ($past(stat) & ~stat) == '0);

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat & $past(set_ev & ~RSVD)) == $past(set_ev & ~RSVD));

  assert_pend_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid == (m != '0));

  assert_pend_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (m[NSRC-1-top_id] &&
                   ((m & ~({NSRC{1'b1}} >> top_id)) == '0)));
endmodule

bind irq_hub irq_hub_chk #(.RSVD(RSVD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .set_ev(set_ev), .stat(stat_q), .en(en_q), .crit(crit_q),
  .irq_norm(irq_norm), .irq_crit(irq_crit), .top_valid(top_valid),
  .top_id(top_id)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_crit, top_valid;
  logic [4:0]  top_id;

  int checks = 0, failures = 0;
  bit done = 0;
  localparam logic [31:0] RSVD = 32'h0000_7000;
  localparam logic [31:0] ALL  = 32'hFFFF_FFFF;

  always #10 clk = ~clk;  // 50 MHz

  irq_hub u0 (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_norm(irq_norm), .irq_crit(irq_crit), .top_valid(top_valid),
    .top_id(top_id));

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] pend_word(input logic [31:0] msk);
    for (int n = 0; n < 32; n++)
      if (msk[31-n]) return {1'b1, 26'd0, 5'(n)};
    return 32'd0;
  endfunction

  function automatic logic [31:0] bit_of(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hold, p, c, e, s, act, msk;
    void'($urandom(32'd20240611));
    idle(3); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 irq_norm after reset", {31'd0, irq_norm}, 32'd0);
    chk("R10 irq_crit after reset", {31'd0, irq_crit}, 32'd0);
    rd(5'h04, d); chk("R10 enable reset", d, 32'd0);
    rd(5'h18, d); chk("R10 pending reset", d, 32'd0);
    idle(4);
    rd(5'h00, d); chk("R10 R9 active-low level status", d, ~RSVD);

    // active-high, level, ordinary routing
    wr(5'h0C, ALL); wr(5'h08, ALL); idle(4);
    wr(5'h00, ALL); idle(1);
    rd(5'h00, d); chk("R5 cleared with active-high idle inputs", d, 32'd0);

    irq_src[5] = 1'b1; idle(5);
    rd(5'h00, d); chk("R1 source 5 at bit 26", d, bit_of(5));
    wr(5'h00, bit_of(5)); idle(1);
    rd(5'h00, d); chk("R3 level re-sets after clear", d, bit_of(5));
    irq_src[5] = 1'b0; idle(5);
    wr(5'h00, 32'd0);
    rd(5'h00, d); chk("R2 write 0 keeps bit", d, bit_of(5));
    wr(5'h00, bit_of(5));
    rd(5'h00, d); chk("R2 write 1 clears bit", d, 32'd0);

    // edge source 9
    wr(5'h10, bit_of(9)); idle(2);
    irq_src[9] = 1'b1; idle(5);
    rd(5'h00, d); chk("R4 rising edge sets", d, bit_of(9));
    wr(5'h00, bit_of(9)); idle(3);
    rd(5'h00, d); chk("R4 held high stays clear", d, 32'd0);
    irq_src[9] = 1'b0; idle(4); irq_src[9] = 1'b1; idle(5);
    rd(5'h00, d); chk("R4 second edge sets", d, bit_of(9));
    irq_src[9] = 1'b0; wr(5'h10, 32'd0); idle(4); wr(5'h00, ALL);

    // routing and masked register
    irq_src[3] = 1'b1; idle(5);
    wr(5'h04, bit_of(3));
    chk("R6 ordinary route", {30'd0, irq_norm, irq_crit}, 32'd2);
    rd(5'h14, d); chk("R7 masked read", d, bit_of(3));
    wr(5'h08, ~bit_of(3));
    chk("R6 urgent route", {30'd0, irq_norm, irq_crit}, 32'd1);
    wr(5'h04, 32'd0);
    chk("R6 R7 disabled, no output", {30'd0, irq_norm, irq_crit}, 32'd0);
    rd(5'h14, d); chk("R7 masked zero when disabled", d, 32'd0);
    rd(5'h00, d); chk("R7 status kept when disabled", d, bit_of(3));

    // pending number
    irq_src[20] = 1'b1; idle(5);
    wr(5'h04, ALL);
    rd(5'h18, d); chk("R8 pending picks source 3", d, 32'h8000_0003);
    chk("R8 top_id pins", {26'd0, top_valid, top_id}, 32'h23);
    wr(5'h04, ~bit_of(3));
    rd(5'h18, d); chk("R8 pending picks source 20", d, 32'h8000_0014);
    wr(5'h04, 32'd0);
    rd(5'h18, d); chk("R8 nothing pending", d, 32'd0);

    // reserved
    irq_src = 32'd0; irq_src[18] = 1'b1; idle(5);
    wr(5'h00, ALL); idle(1);
    rd(5'h00, d); chk("R9 reserved source 18 ignored", d, 32'd0);
    wr(5'h04, ALL);
    rd(5'h04, d); chk("R9 reserved enable bits read 0", d, ~RSVD);
    hold = d;
    wr(5'h04, 32'd0);
    chk("R11 read data holds without read", rdata, hold);
    rd(5'h1C, d); chk("R11 unmapped offset reads 0", d, 32'd0);

    // random level patterns
    for (int it = 0; it < 40; it++) begin
      p = $urandom; c = $urandom; e = $urandom; s = $urandom;
      if (it == 0) begin p = 32'd0; s = 32'd0; end
      wr(5'h0C, p); wr(5'h08, c); wr(5'h04, e);
      irq_src = s; idle(5);
      wr(5'h00, ALL); idle(1);
      act = ~(rev32(s) ^ p) & ~RSVD;
      msk = act & e;
      rd(5'h00, d); chk("R5 R1 random status", d, act);
      rd(5'h14, d); chk("R7 random masked", d, msk);
      rd(5'h18, d); chk("R8 random pending", d, pend_word(msk));
      chk("R6 random outputs", {30'd0, irq_norm, irq_crit},
          {30'd0, |(msk & c), |(msk & ~c)});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule